// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic timer for a processor subsystem. It sits behind a small word-indexed register port and exposes four 32-bit words. Three of them are writable: a control/status word, a 24-bit reload value and the running counter. The fourth is a read-only calibration word. Once it is armed, the counter steps down by one on each counting clock. On a counting clock where the counter is already zero, it picks up the reload value. The step from 1 to 0 is the tick. Each tick sets a sticky flag that software polls, and can also produce a one-cycle interrupt request.

Counting clocks come from one of two sources: every core clock cycle, or only the cycles on which an external reference pulse input is high. Software picks the source through a bit in the control word. A build-time strap can declare that the reference is absent. In that case the core-clock source is locked in. The calibration word carries a 10 ms reload count and two flags, all set from parameters.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current words read 0. The only exception is the clock-source bit, which reads the no-reference strap. The interrupt output is low.
- R2: In the control word, bit 0 arms the counter, bit 1 enables the interrupt, bit 2 selects the core clock (1) or the reference pulse (0), and bit 16 is the tick flag. All other bits read 0. The reload word keeps bits 23:0 and reads 0 in bits 31:24.
- R3: When the counter is armed, each counting clock loads the reload value if the counter is 0 and otherwise decrements it. A reload value of N therefore gives one tick every N+1 counting clocks.
- R4: A tick sets the flag at bit 16. A read of the control word returns the flag and clears it. If a tick and that read fall in the same cycle, the flag ends up set.
- R5: A write to the current word (index 2) forces the counter to 0, whatever data is written. That write takes priority over counting. Bits 31:24 of the current word read 0.
- R6: The interrupt output goes high for exactly one cycle, in the cycle after each tick, and only when bit 1 of the control word is set.
- R7: With bit 2 set to 0, the counter moves only on cycles where the reference pulse input is high. With bit 2 set to 1, it moves on every cycle.
- R8: With bit 0 clear, the counter holds its value even if counting clocks arrive.
- R9: The calibration word (index 3) reads as the no-reference flag in bit 31, the inexact flag in bit 30, zeros in bits 29:24 and the 10 ms count in bits 23:0. Writes to it have no effect.
- R10: With the no-reference strap set, the clock-source bit reads 1 and a write of 0 does not clear it.
- R11: With a reload value of 0, an armed counter stays at 0 and no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | External reference pulse; one counting clock per high cycle when selected |
| bus_idx | input | 2 | Word index: 0 control, 1 reload, 2 current, 3 calibration |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the read-to-clear flag) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_idx |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The hardest case to reach is a tick that lands in the same cycle as the control-word read that would clear the flag. The core clock gives no control over which cycle the counter hits zero, so the bench selects the reference-pulse source instead. It then moves the counter one step at a time down to 1 and raises the reference pulse in the same cycle as the read strobe. The bench also counts the gap between interrupt pulses in core-clock mode to confirm the N+1 period. A second instance with the no-reference strap set covers the locked clock-source bit.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned NUM_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

  // word indices on the register port
  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [IDX_W-1:0] IDX_LOAD = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CUR  = 2'd2;
  localparam logic [IDX_W-1:0] IDX_CAL  = 2'd3;

  // control word bit positions
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IRQ  = 1;
  localparam int unsigned BIT_CORE = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic core;   // 1: core clock, 0: reference pulse
    logic irq;    // interrupt enable
    logic run;    // counter armed
  } ctrl_t;
endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_core,
  input  logic             ref_tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             strobe;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    strobe  = run && (use_core || ref_tick);
    cnt_en  = clr || strobe;
    cnt_nxt = cnt_q;
    if (clr)                cnt_nxt = ZERO;
    else if (cnt_q == ZERO) cnt_nxt = reload;
    else                    cnt_nxt = cnt_q - ONE;
    hit = strobe && !clr && (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  // R3: zero reloads on a counting clock
  a_r3_reload_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !clr && cnt_q == ZERO) |=> (cnt_q == $past(reload)));
  // R3: nonzero value steps down by one
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !clr && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));
  // R5: write to current word zeroes the counter
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == ZERO));
  // R8: no counting clock, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = '0,
  parameter bit          CAL_SKEW  = 1'b0,
  parameter bit          CAL_NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - 2 - CNT_W;
  localparam logic [DATA_W-1:0] CAL_WORD =
    {CAL_NOREF, CAL_SKEW, {PAD_W{1'b0}}, CAL_TENMS};

  ctrl_t            ctrl_q, ctrl_nxt;
  logic             flag_q, flag_nxt;
  logic [CNT_W-1:0] load_q;
  logic             ctrl_wr, ctrl_rd, load_wr;
  logic             unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  always_comb begin
    ctrl_wr  = wr && (idx == IDX_CTRL);
    ctrl_rd  = rd && (idx == IDX_CTRL);
    load_wr  = wr && (idx == IDX_LOAD);
    cur_clr  = wr && (idx == IDX_CUR);
    ctrl_nxt.run  = wdata[BIT_RUN];
    ctrl_nxt.irq  = wdata[BIT_IRQ];
    ctrl_nxt.core = CAL_NOREF ? 1'b1 : wdata[BIT_CORE];
    flag_nxt = hit ? 1'b1 : (ctrl_rd ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{core: CAL_NOREF, irq: 1'b0, run: 1'b0};
      flag_q <= 1'b0;
      load_q <= '0;
    end else begin
      if (ctrl_wr)          ctrl_q <= ctrl_nxt;
      if (hit || ctrl_rd)   flag_q <= flag_nxt;
      if (load_wr)          load_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_CTRL: begin
        rdata[BIT_RUN]  = ctrl_q.run;
        rdata[BIT_IRQ]  = ctrl_q.irq;
        rdata[BIT_CORE] = ctrl_q.core;
        rdata[BIT_FLAG] = flag_q;
      end
      IDX_LOAD: rdata[CNT_W-1:0] = load_q;
      IDX_CUR:  rdata[CNT_W-1:0] = cnt;
      default:  rdata = CAL_WORD;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reload = load_q;

  // R4: a tick always leaves the flag set
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R4: flag only drops on a control read
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctrl_rd) |=> flag_q);
  // R10: strap locks the clock-source bit
  a_r10_core_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.core || !CAL_NOREF));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = 24'd1000000,
  parameter bit          CAL_SKEW  = 1'b1,
  parameter bit          CAL_NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [1:0]        bus_idx,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             cur_clr;
  logic             hit;
  logic             irq_q, irq_nxt;

  tick_timer_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CAL_TENMS(CAL_TENMS),
    .CAL_SKEW(CAL_SKEW), .CAL_NOREF(CAL_NOREF)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .idx(bus_idx), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt), .hit(hit), .ctrl(ctrl),
    .reload(reload), .cur_clr(cur_clr), .rdata(bus_rdata)
  );

  tick_timer_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .use_core(ctrl.core),
    .ref_tick(ref_tick), .clr(cur_clr), .reload(reload),
    .cnt(cnt), .hit(hit)
  );

  always_comb irq_nxt = hit && ctrl.irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assign tick_irq = irq_q;

  // R6: request only follows a tick with interrupts enabled
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> ($past(hit) && $past(ctrl.irq)));
  // R6: request is a single-cycle pulse
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  bus_idx = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_nr;
  logic        tick_irq, tick_irq_nr;

  int checks = 0;
  int errors = 0;
  int irq_total = 0;

  always #4 clk = ~clk;   // 125 MHz

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_idx(bus_idx),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .tick_irq(tick_irq)
  );

  tick_timer #(.CAL_TENMS(24'd0), .CAL_SKEW(1'b0), .CAL_NOREF(1'b1)) dut_nr_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_idx(bus_idx),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_nr), .tick_irq(tick_irq_nr)
  );

  always @(posedge clk) if (tick_irq) irq_total <= irq_total + 1;

  typedef struct packed {
    logic        wr;
    logic [1:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h0,        32'h0000_0000, 8'd1},  // R1 control
    '{1'b0, 2'd1, 32'h0,        32'h0000_0000, 8'd1},  // R1 reload
    '{1'b0, 2'd2, 32'h0,        32'h0000_0000, 8'd1},  // R1 current
    '{1'b0, 2'd3, 32'h0,        32'h400F_4240, 8'd9},  // R9 calibration
    '{1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0,        8'd2},
    '{1'b0, 2'd1, 32'h0,        32'h00FF_FFFF, 8'd2},  // R2 reload width
    '{1'b1, 2'd0, 32'hFFFF_FFF8, 32'h0,        8'd2},
    '{1'b0, 2'd0, 32'h0,        32'h0000_0000, 8'd2},  // R2 reserved bits
    '{1'b1, 2'd3, 32'h1234_5678, 32'h0,        8'd9},
    '{1'b0, 2'd3, 32'h0,        32'h400F_4240, 8'd9},  // R9 write ignored
    '{1'b1, 2'd0, 32'h0000_0006, 32'h0,        8'd2},
    '{1'b0, 2'd0, 32'h0,        32'h0000_0006, 8'd2},  // R2 fields
    '{1'b1, 2'd1, 32'h0000_0005, 32'h0,        8'd2},
    '{1'b0, 2'd1, 32'h0,        32'h0000_0005, 8'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, input logic pulse,
                    output logic [31:0] d, output logic [31:0] dnr);
    @(negedge clk);
    bus_idx = idx; bus_rd = 1'b1; ref_tick = pulse;
    #1;
    d = rdata; dnr = rdata_nr;
    @(negedge clk);
    bus_rd = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic pulse_ref();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, dn;
    int base, gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq low", {31'd0, tick_irq}, 32'd0);
    rd(2'd0, 1'b0, d, dn);
    chk("R10 strap reset ctrl", dn, 32'h4);
    rd(2'd3, 1'b0, d, dn);
    chk("R9 strap cal", dn, 32'h8000_0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].idx, VECS[i].data);
      else begin
        rd(VECS[i].idx, 1'b0, d, dn);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
      end
    end

    // R7 reference-pulse counting, R3 reload, R4 flag
    wr(2'd1, 32'd3); wr(2'd2, 32'd0); wr(2'd0, 32'h1);
    base = irq_total;
    rd(2'd2, 1'b0, d, dn); chk("R7 no pulse no count", d, 32'd0);
    pulse_ref();
    rd(2'd2, 1'b0, d, dn); chk("R3 load from zero", d, 32'd3);
    repeat (5) @(negedge clk);
    rd(2'd2, 1'b0, d, dn); chk("R7 idle hold", d, 32'd3);
    pulse_ref();
    rd(2'd2, 1'b0, d, dn); chk("R3 decrement", d, 32'd2);
    pulse_ref(); pulse_ref();
    rd(2'd0, 1'b0, d, dn); chk("R4 flag set", d, 32'h0001_0001);
    rd(2'd0, 1'b0, d, dn); chk("R4 flag cleared by read", d, 32'h1);
    chk("R6 no irq when disabled", irq_total - base, 0);

    // R8 disarmed counter holds
    pulse_ref();
    wr(2'd0, 32'h0);
    pulse_ref();
    rd(2'd2, 1'b0, d, dn); chk("R8 hold when disarmed", d, 32'd3);

    // R5 any write zeroes current
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd2, 1'b0, d, dn); chk("R5 current cleared", d, 32'd0);

    // R4 tick during the clearing read
    wr(2'd1, 32'd1); wr(2'd0, 32'h1);
    pulse_ref();
    rd(2'd2, 1'b0, d, dn); chk("R3 reload 1", d, 32'd1);
    rd(2'd0, 1'b1, d, dn); chk("R4 read before tick", d, 32'h1);
    rd(2'd0, 1'b0, d, dn); chk("R4 set wins over clear", d, 32'h0001_0001);

    // R3/R6 core-clock period and pulse width
    wr(2'd0, 32'h0); wr(2'd2, 32'd0); wr(2'd1, 32'd3);
    rd(2'd0, 1'b0, d, dn);
    wr(2'd0, 32'h7);
    for (int i = 0; i < 50 && !tick_irq; i++) @(negedge clk);
    chk("R6 irq seen", {31'd0, tick_irq}, 32'd1);
    @(negedge clk);
    chk("R6 one-cycle pulse", {31'd0, tick_irq}, 32'd0);
    gap = 1;
    for (int i = 0; i < 50 && !tick_irq; i++) begin
      @(negedge clk);
      gap++;
    end
    chk("R3 period reload+1", gap, 32'd4);
    wr(2'd0, 32'h0);

    // R11 reload zero never ticks
    wr(2'd2, 32'd0); wr(2'd1, 32'd0);
    rd(2'd0, 1'b0, d, dn);
    base = irq_total;
    wr(2'd0, 32'h7);
    repeat (20) @(negedge clk);
    rd(2'd2, 1'b0, d, dn); chk("R11 stays zero", d, 32'd0);
    rd(2'd0, 1'b0, d, dn); chk("R11 no flag", d, 32'h7);
    chk("R11 no irq", irq_total - base, 0);

    // R10 strap keeps core source
    wr(2'd0, 32'h0);
    rd(2'd0, 1'b0, d, dn);
    chk("R10 core bit locked", dn, 32'h4);
    chk("R10 normal instance clears", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule